// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt conditions of a UART and reduces them to one interrupt line and one status byte. The sources are receive line errors, receive data at its trigger level, a receive timeout, an empty transmit buffer and a modem status change. Each source has its own enable bit. When several enabled sources are active at once, the status byte reports the most urgent of them as a 3-bit cause code. The receive-timeout detector is part of the block. It counts character-period ticks while receive data is waiting and fires when no read has taken it for a fixed number of character times.

A single register address serves two purposes. A write to it sets the FIFO-mode bit, which chooses between a 16-entry buffer and a single-word holding register for both the transmit and receive paths. A write that changes this bit also emits a one-cycle flush request. A read from the address returns the interrupt status byte. The byte shows whether anything is pending, the cause code and the current buffer mode. Reading the status when it names the transmit-empty cause acknowledges that cause.

Top module: `uart_irq_ident`

## Requirements
- R1: A write strobe loads `reg_wdata[0]` into the FIFO-mode bit. A read strobe captures the status byte into `reg_rdata`, which is valid from the clock edge that sampled the strobe and holds its value until the next read.
- R2: `fifo_en` resets to 0. `buf_depth` is 16 while `fifo_en` is 1 and 1 while it is 0, and it follows the new mode from the cycle after the write.
- R3: Status bit 0 is active low. It reads 0 when any enabled source is active and 1 when none is.
- R4: Status bits 3:1 carry the cause of the highest-priority active enabled source. The codes are line error = 3, receive data = 2, receive timeout = 6, transmit empty = 1 and modem change = 0, and the ranking runs from highest to lowest in that order. The field reads 0 when nothing is pending.
- R5: Status bits 7:6 read 2'b11 in FIFO mode and 2'b00 otherwise. Bits 5:4 always read 0.
- R6: `irq_en` bit 0 enables both receive data and receive timeout. Bit 1 enables transmit empty, bit 2 enables line error and bit 3 enables modem change. A source whose enable bit is 0 has no effect on the status byte or on `irq`.
- R7: The receive timeout becomes active once 4 `char_tick` pulses have arrived while `rx_nonempty` is high with no `rx_char_in` or `rx_data_rd` in between. It drops on `rx_data_rd`. Fewer ticks do not raise it.
- R8: The transmit-empty source arms when `tx_empty` rises or when `tx_data_wr` pulses. A status read that reports cause 1 disarms it. A status read that reports a different cause leaves it armed.
- R9: A write that changes the FIFO-mode bit raises `fifo_flush` for exactly the next cycle and clears the timeout count. A write of the same value produces no flush.
- R10: `irq` is active high and registered. It equals the inverse of status bit 0 one clock after the sources change.
- R11: After reset, `reg_rdata` is 0x00, `irq` is 0 and `fifo_flush` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 4 | Per-source enables: [0] receive data and timeout, [1] transmit empty, [2] line error, [3] modem change |
| line_err | input | 1 | Receive line error condition |
| rx_ready | input | 1 | Receive data at trigger level |
| rx_nonempty | input | 1 | Receive buffer holds at least one character |
| rx_char_in | input | 1 | Pulse: a character has arrived in the receive buffer |
| rx_data_rd | input | 1 | Pulse: software has read receive data |
| tx_empty | input | 1 | Transmit buffer empty condition |
| tx_data_wr | input | 1 | Pulse: data written into the transmit path |
| modem_chg | input | 1 | Modem status change condition |
| char_tick | input | 1 | One pulse per character period |
| reg_rd | input | 1 | Decoded read strobe for the shared address |
| reg_wr | input | 1 | Decoded write strobe for the shared address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Captured status byte |
| irq | output | 1 | Active-high interrupt line |
| fifo_en | output | 1 | FIFO-mode bit |
| fifo_flush | output | 1 | One-cycle flush request on a mode change |
| buf_depth | output | 5 | Buffer depth for the transmit and receive paths |

## Verification
The block holds three pieces of state: the timeout count, the transmit-empty arm flag and the mode bit. Each is exposed at the ports through the status byte no later than the next read. A stale or miscounted timeout shows up as code 6 appearing one tick too early or staying after a data read. A wrong arm flag shows up as cause 1 surviving its own acknowledgement, or vanishing after a read that reported a higher cause. A mode error shows up in bits 7:6, in `buf_depth` and in the flush pulse within one cycle of the write. The `irq` line is compared against bit 0 of every read, so any skew of the registered line is caught on the read that follows it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        CAUSE_MODEM = 3'd0,
        CAUSE_TXE   = 3'd1,
        CAUSE_RXD   = 3'd2,
        CAUSE_LINE  = 3'd3,
        CAUSE_RTO   = 3'd6
    } cause_e;

    typedef struct packed {
        logic [1:0] mode;
        logic [1:0] rsvd;
        cause_e     cause;
        logic       idle_n;
    } status_t;

    typedef struct packed {
        logic line;
        logic rxd;
        logic rto;
        logic txe;
        logic modem;
    } src_t;

    function automatic status_t make_status(input logic fifo_on,
                                            input logic pend,
                                            input cause_e c);
        status_t s;
        s.mode   = fifo_on ? 2'b11 : 2'b00;
        s.rsvd   = 2'b00;
        s.cause  = c;
        s.idle_n = ~pend;
        return s;
    endfunction

endpackage

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
    parameter int CHARS = 4,
    localparam int CW = $clog2(CHARS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic nonempty,
    input  logic char_in,
    input  logic data_rd,
    input  logic flush,
    input  logic tick,
    output logic expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !nonempty || char_in || data_rd || flush) begin
            cnt <= '0;
        end else if (tick && cnt != CW'(CHARS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == CW'(CHARS));

    AST_RTO_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> !expired); // R7
    AST_RTO_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> !expired); // R9
endmodule

// File: rtl/uart_txe_arm.sv
module uart_txe_arm (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty,
    input  logic tx_wr,
    input  logic ack,
    output logic active
);
    logic prev_empty;
    logic armed;
    logic set_ev;

    assign set_ev = (tx_empty && !prev_empty) || tx_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_empty <= 1'b0;
            armed      <= 1'b0;
        end else begin
            prev_empty <= tx_empty;
            if (set_ev)
                armed <= 1'b1;
            else if (ack)
                armed <= 1'b0;
        end
    end

    assign active = armed && tx_empty;

    AST_TXE_ACK_DISARMS: assert property (@(posedge clk) disable iff (rst)
        (ack && !set_ev) |=> !active); // R8
    AST_TXE_WR_ARMS: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_empty) |=> (active || !tx_empty)); // R8
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  src_t   src,
    output logic   pend,
    output cause_e cause
);
    always_comb begin
        pend  = 1'b1;
        cause = CAUSE_MODEM;
        if (src.line)       cause = CAUSE_LINE;
        else if (src.rxd)   cause = CAUSE_RXD;
        else if (src.rto)   cause = CAUSE_RTO;
        else if (src.txe)   cause = CAUSE_TXE;
        else if (src.modem) cause = CAUSE_MODEM;
        else                pend  = 1'b0;
    end

    AST_PRIO_ONE_SOURCE: assert final (!$onehot(src) || pend); // R3
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int TIMEOUT_CHARS = 4,
    parameter int DEPTH_FIFO    = 16,
    parameter int DEPTH_SINGLE  = 1,
    localparam int DW = $clog2(DEPTH_FIFO + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    irq_en,
    input  logic          line_err,
    input  logic          rx_ready,
    input  logic          rx_nonempty,
    input  logic          rx_char_in,
    input  logic          rx_data_rd,
    input  logic          tx_empty,
    input  logic          tx_data_wr,
    input  logic          modem_chg,
    input  logic          char_tick,
    input  logic          reg_rd,
    input  logic          reg_wr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          irq,
    output logic          fifo_en,
    output logic          fifo_flush,
    output logic [DW-1:0] buf_depth
);
    logic    flush_req;
    logic    rto_hit;
    logic    txe_act;
    logic    txe_ack;
    logic    pend;
    cause_e  cause;
    src_t    src;
    status_t stat;

    assign flush_req = reg_wr && (reg_wdata[0] != fifo_en);

    uart_rx_timeout #(.CHARS(TIMEOUT_CHARS)) u_rto (
        .clk      (clk),
        .rst      (rst),
        .nonempty (rx_nonempty),
        .char_in  (rx_char_in),
        .data_rd  (rx_data_rd),
        .flush    (flush_req),
        .tick     (char_tick),
        .expired  (rto_hit)
    );

    assign txe_ack = reg_rd && pend && (cause == CAUSE_TXE);

    uart_txe_arm u_txe (
        .clk      (clk),
        .rst      (rst),
        .tx_empty (tx_empty),
        .tx_wr    (tx_data_wr),
        .ack      (txe_ack),
        .active   (txe_act)
    );

    always_comb begin
        src.line  = line_err  && irq_en[2];
        src.rxd   = rx_ready  && irq_en[0];
        src.rto   = rto_hit   && irq_en[0];
        src.txe   = txe_act   && irq_en[1];
        src.modem = modem_chg && irq_en[3];
    end

    uart_irq_prio u_prio (
        .src   (src),
        .pend  (pend),
        .cause (cause)
    );

    assign stat = make_status(fifo_en, pend, cause);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_en    <= 1'b0;
            fifo_flush <= 1'b0;
            reg_rdata  <= 8'h00;
            irq        <= 1'b0;
        end else begin
            fifo_flush <= flush_req;
            irq        <= pend;
            if (reg_wr)
                fifo_en <= reg_wdata[0];
            if (reg_rd)
                reg_rdata <= stat;
        end
    end

    assign buf_depth = fifo_en ? DW'(DEPTH_FIFO) : DW'(DEPTH_SINGLE);

    AST_WRITE_SETS_MODE: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> (fifo_en == $past(reg_wdata[0]))); // R1
    AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (rst)
        reg_rd |=> (reg_rdata[0] == !irq)); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5:4] == 2'b00); // R5
    AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && line_err && irq_en[2]) |=> (reg_rdata[3:0] == 4'b0110)); // R4
    AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |-> (fifo_en != $past(fifo_en))); // R9
endmodule

// File: tb/sim_uart_irq_ident.sv
module sim_uart_irq_ident;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] irq_en;
    logic       line_err, rx_ready, rx_nonempty, rx_char_in, rx_data_rd;
    logic       tx_empty, tx_data_wr, modem_chg, char_tick;
    logic       reg_rd, reg_wr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       irq, fifo_en, fifo_flush;
    logic [4:0] buf_depth;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    uart_irq_ident u0 (
        .clk(clk), .rst(rst), .irq_en(irq_en), .line_err(line_err),
        .rx_ready(rx_ready), .rx_nonempty(rx_nonempty), .rx_char_in(rx_char_in),
        .rx_data_rd(rx_data_rd), .tx_empty(tx_empty), .tx_data_wr(tx_data_wr),
        .modem_chg(modem_chg), .char_tick(char_tick), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .fifo_en(fifo_en), .fifo_flush(fifo_flush), .buf_depth(buf_depth)
    );

    // {irq_en[3:0], line_err, rx_ready, modem_chg, expected status byte}
    localparam int NV = 8;
    localparam logic [14:0] VEC [NV] = '{
        {4'b0000, 3'b111, 8'h01},
        {4'b1111, 3'b111, 8'h06},
        {4'b1111, 3'b011, 8'h04},
        {4'b1111, 3'b001, 8'h00},
        {4'b0100, 3'b011, 8'h01},
        {4'b1011, 3'b100, 8'h01},
        {4'b1000, 3'b001, 8'h00},
        {4'b0001, 3'b110, 8'h04}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_read();
        @(negedge clk) reg_rd = 1'b1;
        @(negedge clk) reg_rd = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = v; end
        @(negedge clk) reg_wr = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk) char_tick = 1'b1;
        @(negedge clk) char_tick = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++;
                total++;
                $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; irq_en = '0; line_err = 0; rx_ready = 0; rx_nonempty = 0;
        rx_char_in = 0; rx_data_rd = 0; tx_empty = 0; tx_data_wr = 0;
        modem_chg = 0; char_tick = 0; reg_rd = 0; reg_wr = 0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check("R11 rdata", reg_rdata, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);
        check("R11 flush", {7'd0, fifo_flush}, 8'h00);
        check("R2 reset depth", {3'd0, buf_depth}, 8'd1);

        // R4 R6 R3 R10: priority and enable table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk) begin
                irq_en    = VEC[i][14:11];
                line_err  = VEC[i][10];
                rx_ready  = VEC[i][9];
                modem_chg = VEC[i][8];
            end
            do_read();
            check("R4 R6 status", reg_rdata, VEC[i][7:0]);
            check("R10 irq", {7'd0, irq}, {7'd0, ~VEC[i][0]});
        end
        @(negedge clk) begin line_err = 0; rx_ready = 0; modem_chg = 0; irq_en = 4'b0010; end

        // R8 transmit empty arm and acknowledge
        @(negedge clk) tx_empty = 1'b1;
        do_read();
        check("R8 txe reported", reg_rdata, 8'h02);
        do_read();
        check("R8 txe cleared by read", reg_rdata, 8'h01);
        @(negedge clk) tx_data_wr = 1'b1;
        @(negedge clk) tx_data_wr = 1'b0;
        @(negedge clk) begin irq_en = 4'b0110; line_err = 1'b1; end
        do_read();
        check("R8 line outranks txe", reg_rdata, 8'h06);
        @(negedge clk) line_err = 1'b0;
        do_read();
        check("R8 txe kept after other cause", reg_rdata, 8'h02);
        do_read();
        @(negedge clk) begin tx_empty = 1'b0; irq_en = 4'b0001; end

        // R7 receive timeout
        @(negedge clk) rx_nonempty = 1'b1;
        repeat (3) pulse_tick();
        do_read();
        check("R7 no timeout after 3", reg_rdata, 8'h01);
        pulse_tick();
        do_read();
        check("R7 timeout after 4", reg_rdata, 8'h0C);
        @(negedge clk) rx_ready = 1'b1;
        do_read();
        check("R4 rxd above timeout", reg_rdata, 8'h04);
        @(negedge clk) begin rx_ready = 1'b0; rx_data_rd = 1'b1; end
        @(negedge clk) rx_data_rd = 1'b0;
        do_read();
        check("R7 read clears timeout", reg_rdata, 8'h01);
        repeat (3) pulse_tick();
        @(negedge clk) rx_char_in = 1'b1;
        @(negedge clk) rx_char_in = 1'b0;
        pulse_tick();
        do_read();
        check("R7 arrival restarts count", reg_rdata, 8'h01);

        // R9 R2 R5 FIFO mode and flush
        repeat (3) pulse_tick();
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = 8'h01; end
        @(negedge clk) reg_wr = 1'b0;
        check("R9 flush pulse", {7'd0, fifo_flush}, 8'h01);
        check("R2 depth 16", {3'd0, buf_depth}, 8'd16);
        @(negedge clk);
        check("R9 flush one cycle", {7'd0, fifo_flush}, 8'h00);
        pulse_tick();
        do_read();
        check("R9 flush clears timeout", reg_rdata, 8'hC1);
        check("R5 mode bits", {6'd0, reg_rdata[7:6]}, 8'h03);
        repeat (3) pulse_tick();
        do_read();
        check("R7 timeout in fifo mode", reg_rdata, 8'hCC);
        @(negedge clk) begin reg_wr = 1'b1; reg_wdata = 8'hFF; end
        @(negedge clk) reg_wr = 1'b0;
        check("R9 same value no flush", {7'd0, fifo_flush}, 8'h00);
        do_read();
        check("R1 read after rewrite", reg_rdata, 8'hCC);
        do_write(8'hFE);
        check("R2 depth 1", {3'd0, buf_depth}, 8'd1);
        check("R1 mode cleared", {7'd0, fifo_en}, 8'h00);
        do_read();
        check("R1 status after clear", reg_rdata, 8'h01);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule